// File: doc/BRIEF.md
# Vectored Interrupt Mask Unit

This block is the interrupt front end of a small 8-bit processor core. Five request pins reach it directly: a non-maskable trap, three maskable restart inputs ranked 7.5, 6.5 and 5.5, and one general request. Each restart input has its own pin, so a simple system needs no external interrupt controller. The block holds a mask bit for each restart input, a global enable and the pending state of the restart inputs.

The core drives the block with single-cycle strobes. Enable and disable strobes set and clear the global enable. A set-mask strobe carries a data byte. An acknowledge strobe tells the block that the core has taken the request on offer. The block always presents a status byte that holds the mask, enable and pending state. It also presents a request flag, a flag that marks the request as vectored, and the restart address of the winning source.

Every request pin and every strobe is registered once. All outputs are decoded from those registers, so any stimulus shows at the outputs right after the next rising clock edge.

Top module: `irq_mask_unit`

## Requirements
- R1: After reset the three restart masks are set, status_o reads 0x07, the global enable and all pending state are clear, and irq_o is low.
- R2: A set-mask strobe whose data bit 3 is 1 loads data bits 2:0 into the masks: bit 2 is 7.5, bit 1 is 6.5 and bit 0 is 5.5, and 1 means masked. When bit 3 is 0 the masks keep their values.
- R3: A set-mask strobe whose data bit 4 is 1 clears the 7.5 pending latch.
- R4: status_o reads as follows. Bit 7 is 0. Bits 6:4 are pending 7.5, 6.5 and 5.5. Bit 3 is the global enable. Bits 2:0 are the masks for 7.5, 6.5 and 5.5.
- R5: A rising edge on the 7.5 input sets its pending latch whatever the mask and enable are. The latch holds after the input falls. The 6.5 and 5.5 pending bits follow their input levels and are not held.
- R6: The sources are ranked trap, then 7.5, then 6.5, then 5.5, then the general request. The vector addresses are 0x0024, 0x003C, 0x0034 and 0x002C for the first four.
- R7: A restart input is offered only when it is pending, unmasked and the global enable is set. The general request is offered only when the global enable is set, and it is offered with vectored_o low and vector_o at 0.
- R8: The trap input is offered whenever it is high, whatever the enable and masks are.
- R9: An acknowledge strobe while irq_o is high clears the global enable. If the 7.5 source was on offer, the strobe also clears the 7.5 pending latch.
- R10: The enable strobe sets the global enable. The disable strobe clears it and wins over the enable strobe. An accepted acknowledge also wins over the enable strobe.
- R11: The outputs reflect any pin or strobe change one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_i | input | 1 | Non-maskable request |
| rst75_i | input | 1 | Restart 7.5 request, edge latched |
| rst65_i | input | 1 | Restart 6.5 request, level |
| rst55_i | input | 1 | Restart 5.5 request, level |
| intr_i | input | 1 | General request |
| ei_i | input | 1 | Set global enable strobe |
| di_i | input | 1 | Clear global enable strobe |
| set_mask_i | input | 1 | Set-mask strobe |
| mask_data_i | input | 8 | Set-mask data byte |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| irq_o | output | 1 | Request on offer to the core |
| vectored_o | output | 1 | The offered request carries a vector |
| vector_o | output | 16 | Restart address of the offered request |
| status_o | output | 8 | Read-mask status byte |

## Verification
Every pin and strobe passes through exactly one register. The enable, mask, pending, status and vector results of a stimulus are therefore all due one edge after the stimulus is applied. The bench applies each stimulus row at a falling edge and compares all four outputs at the following falling edge, which lies after exactly one rising edge. The acknowledge rows rely on the same rule: an acknowledge acts on the source that is already on offer when it is applied, and its effect appears at the next falling edge.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
    localparam int NUM_RST  = 3;
    localparam int DATA_W   = 8;
    localparam int VEC_W    = 16;
    localparam int IDX_W    = $clog2(NUM_RST);
    localparam int STAT_W   = 2 * NUM_RST + 1;
    localparam int SM_ENA_BIT   = NUM_RST;
    localparam int SM_CLRTOP_BIT = NUM_RST + 1;

    localparam logic [VEC_W-1:0] TRAP_VEC = 16'h0024;
    localparam logic [VEC_W-1:0] RST_BASE = 16'h002C;
    localparam logic [VEC_W-1:0] RST_STEP = 16'h0008;

    typedef struct packed {
        logic [NUM_RST-1:0] mask;
        logic [NUM_RST-1:0] pend;
        logic               ien;
        logic               prev_top;
        logic               trap;
        logic               intr;
    } state_t;
endpackage

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
    import irq_mask_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_i,
    input  logic [NUM_RST-1:0] req_i,
    input  logic               intr_i,
    input  logic               ei_i,
    input  logic               di_i,
    input  logic               set_mask_i,
    input  logic [DATA_W-1:0]  mask_data_i,
    input  logic               ack_i,
    input  logic               taken_i,
    input  logic               top_sel_i,
    output logic [NUM_RST-1:0] mask_o,
    output logic [NUM_RST-1:0] pend_o,
    output logic               ien_o,
    output logic               trap_o,
    output logic               intr_o
);
    localparam int TOP = NUM_RST - 1;

    state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.trap     = trap_i;
        st_d.intr     = intr_i;
        st_d.prev_top = req_i[TOP];
        // lower restart inputs are sampled levels
        st_d.pend[TOP-1:0] = req_i[TOP-1:0];
        // top restart input: edge latch, cleared by software or acceptance
        if (set_mask_i && mask_data_i[SM_CLRTOP_BIT]) st_d.pend[TOP] = 1'b0;
        if (ack_i && taken_i && top_sel_i)            st_d.pend[TOP] = 1'b0;
        if (req_i[TOP] && !st_q.prev_top)             st_d.pend[TOP] = 1'b1;
        if (set_mask_i && mask_data_i[SM_ENA_BIT])
            st_d.mask = mask_data_i[NUM_RST-1:0];
        if (ei_i)             st_d.ien = 1'b1;
        if (di_i)             st_d.ien = 1'b0;
        if (ack_i && taken_i) st_d.ien = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o = st_q.mask;
    assign pend_o = st_q.pend;
    assign ien_o  = st_q.ien;
    assign trap_o = st_q.trap;
    assign intr_o = st_q.intr;
endmodule

// File: rtl/irq_mask_prio.sv
module irq_mask_prio
    import irq_mask_pkg::*;
(
    input  logic [NUM_RST-1:0] mask_i,
    input  logic [NUM_RST-1:0] pend_i,
    input  logic               ien_i,
    input  logic               trap_i,
    input  logic               intr_i,
    output logic               irq_o,
    output logic               vectored_o,
    output logic [VEC_W-1:0]   vector_o,
    output logic               top_sel_o
);
    logic [NUM_RST-1:0] live;
    logic [IDX_W-1:0]   win;
    logic               any_rst;

    assign live = pend_i & ~mask_i & {NUM_RST{ien_i}};

    always_comb begin
        win     = '0;
        any_rst = 1'b0;
        // ascending scan: the highest index found last wins
        for (int i = 0; i < NUM_RST; i++) begin
            if (live[i]) begin
                win     = IDX_W'(i);
                any_rst = 1'b1;
            end
        end
    end

    always_comb begin
        irq_o      = 1'b0;
        vectored_o = 1'b0;
        vector_o   = '0;
        top_sel_o  = 1'b0;
        if (trap_i) begin
            irq_o      = 1'b1;
            vectored_o = 1'b1;
            vector_o   = TRAP_VEC;
        end else if (any_rst) begin
            irq_o      = 1'b1;
            vectored_o = 1'b1;
            vector_o   = RST_BASE + RST_STEP * VEC_W'(win);
            top_sel_o  = (win == IDX_W'(NUM_RST - 1));
        end else if (intr_i && ien_i) begin
            irq_o = 1'b1;
        end
    end
endmodule

// File: rtl/irq_mask_unit.sv
module irq_mask_unit
    import irq_mask_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_i,
    input  logic              rst75_i,
    input  logic              rst65_i,
    input  logic              rst55_i,
    input  logic              intr_i,
    input  logic              ei_i,
    input  logic              di_i,
    input  logic              set_mask_i,
    input  logic [DATA_W-1:0] mask_data_i,
    input  logic              ack_i,
    output logic              irq_o,
    output logic              vectored_o,
    output logic [VEC_W-1:0]  vector_o,
    output logic [DATA_W-1:0] status_o
);
    logic [NUM_RST-1:0] mask, pend;
    logic               ien, trap_q, intr_q, top_sel;

    irq_mask_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .trap_i      (trap_i),
        .req_i       ({rst75_i, rst65_i, rst55_i}),
        .intr_i      (intr_i),
        .ei_i        (ei_i),
        .di_i        (di_i),
        .set_mask_i  (set_mask_i),
        .mask_data_i (mask_data_i),
        .ack_i       (ack_i),
        .taken_i     (irq_o),
        .top_sel_i   (top_sel),
        .mask_o      (mask),
        .pend_o      (pend),
        .ien_o       (ien),
        .trap_o      (trap_q),
        .intr_o      (intr_q)
    );

    irq_mask_prio u_prio (
        .mask_i     (mask),
        .pend_i     (pend),
        .ien_i      (ien),
        .trap_i     (trap_q),
        .intr_i     (intr_q),
        .irq_o      (irq_o),
        .vectored_o (vectored_o),
        .vector_o   (vector_o),
        .top_sel_o  (top_sel)
    );

    assign status_o = DATA_W'({pend, ien, mask});
endmodule

// File: rtl/irq_mask_unit_chk.sv
module irq_mask_unit_chk
    import irq_mask_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              trap_i,
    input logic              rst75_i,
    input logic              rst65_i,
    input logic              rst55_i,
    input logic              intr_i,
    input logic              ei_i,
    input logic              di_i,
    input logic              set_mask_i,
    input logic [DATA_W-1:0] mask_data_i,
    input logic              ack_i,
    input logic              irq_o,
    input logic              vectored_o,
    input logic [VEC_W-1:0]  vector_o,
    input logic [DATA_W-1:0] status_o
);
    AST_SETMASK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        set_mask_i && mask_data_i[3] |=> status_o[2:0] == $past(mask_data_i[2:0])); // R2

    AST_ACK_DROPS_IEN: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i && irq_o |=> !status_o[3]); // R9

    AST_ACK_CLEARS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i && irq_o && vector_o == 16'h003C && !rst75_i |=> !status_o[6]); // R9

    AST_RST_NEEDS_IEN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && vectored_o && vector_o != TRAP_VEC |-> status_o[3]); // R7

    AST_GENERAL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && !vectored_o |-> status_o[3] && ((status_o[6:4] & ~status_o[2:0]) == 3'b000)); // R7

    AST_LOW_RANK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && vector_o == 16'h002C |-> !(status_o[5] && !status_o[1]) && !(status_o[6] && !status_o[2])); // R6

    AST_BIT7_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[7]); // R4
endmodule

bind irq_mask_unit irq_mask_unit_chk u_chk (.*);

// File: tb/irq_mask_unit_bench.sv
module irq_mask_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_i = 0, rst75_i = 0, rst65_i = 0, rst55_i = 0, intr_i = 0;
    logic        ei_i = 0, di_i = 0, set_mask_i = 0, ack_i = 0;
    logic [7:0]  mask_data_i = '0;
    logic        irq_o, vectored_o;
    logic [15:0] vector_o;
    logic [7:0]  status_o;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irq_mask_unit u_irq_mask_unit (.*);

    // row: trap r75 r65 r55 intr | ei di sm | data | ack || irq vect | vector | status
    localparam int NROW = 19;
    localparam logic [42:0] TBL [NROW] = '{
        {5'b00000, 3'b100, 8'h00, 1'b0, 2'b00, 16'h0000, 8'h0F}, // R10 enable
        {5'b00000, 3'b001, 8'h08, 1'b0, 2'b00, 16'h0000, 8'h08}, // R2 unmask all
        {5'b00010, 3'b000, 8'h00, 1'b0, 2'b11, 16'h002C, 8'h18}, // R6 5.5
        {5'b00110, 3'b000, 8'h00, 1'b0, 2'b11, 16'h0034, 8'h38}, // R6 6.5 over 5.5
        {5'b01110, 3'b000, 8'h00, 1'b0, 2'b11, 16'h003C, 8'h78}, // R5 edge 7.5
        {5'b11110, 3'b000, 8'h00, 1'b0, 2'b11, 16'h0024, 8'h78}, // R6 trap on top
        {5'b01110, 3'b000, 8'h00, 1'b1, 2'b00, 16'h0000, 8'h70}, // R9 ack trap
        {5'b01110, 3'b100, 8'h00, 1'b0, 2'b11, 16'h003C, 8'h78}, // R10 re-enable
        {5'b01110, 3'b000, 8'h00, 1'b1, 2'b00, 16'h0000, 8'h30}, // R9 ack 7.5
        {5'b01110, 3'b100, 8'h00, 1'b0, 2'b11, 16'h0034, 8'h38}, // R5 no new edge
        {5'b01110, 3'b001, 8'h0A, 1'b0, 2'b11, 16'h002C, 8'h3A}, // R2 mask 6.5
        {5'b01110, 3'b001, 8'h03, 1'b0, 2'b11, 16'h002C, 8'h3A}, // R2 bit3 clear
        {5'b01001, 3'b000, 8'h00, 1'b0, 2'b10, 16'h0000, 8'h0A}, // R7 general
        {5'b01001, 3'b010, 8'h00, 1'b0, 2'b00, 16'h0000, 8'h02}, // R10 disable
        {5'b00000, 3'b100, 8'h00, 1'b0, 2'b00, 16'h0000, 8'h0A}, // R4 idle
        {5'b01000, 3'b001, 8'h0C, 1'b0, 2'b00, 16'h0000, 8'h4C}, // R5 latch while masked
        {5'b01000, 3'b001, 8'h18, 1'b0, 2'b00, 16'h0000, 8'h08}, // R3 clear pending
        {5'b11000, 3'b010, 8'h00, 1'b0, 2'b11, 16'h0024, 8'h00}, // R8 trap ignores enable
        {5'b01000, 3'b000, 8'h00, 1'b0, 2'b00, 16'h0000, 8'h00}  // R11 trap drops
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic quiet_inputs();
        {trap_i, rst75_i, rst65_i, rst55_i, intr_i} = '0;
        {ei_i, di_i, set_mask_i, ack_i} = '0;
        mask_data_i = '0;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        quiet_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 status", 32'(status_o), 32'h07);
        check("R1 irq", 32'(irq_o), 32'h0);

        for (int i = 0; i < NROW; i++) begin
            {trap_i, rst75_i, rst65_i, rst55_i, intr_i} = TBL[i][42:38];
            {ei_i, di_i, set_mask_i}                     = TBL[i][37:35];
            mask_data_i                                  = TBL[i][34:27];
            ack_i                                        = TBL[i][26];
            @(negedge clk);
            check($sformatf("R11 row%0d irq", i),    32'(irq_o),      32'(TBL[i][25]));
            check($sformatf("R6 row%0d vect", i),    32'(vectored_o), 32'(TBL[i][24]));
            check($sformatf("R6 row%0d vector", i),  32'(vector_o),   32'(TBL[i][23:8]));
            check($sformatf("R4 row%0d status", i),  32'(status_o),   32'(TBL[i][7:0]));
        end
        quiet_inputs();
        @(negedge clk);

        // R10: disable wins over a simultaneous enable
        ei_i = 1'b1; di_i = 1'b1;
        @(negedge clk);
        check("R10 di over ei", 32'(status_o[3]), 32'h0);
        quiet_inputs();

        // R5: 6.5 level is not held once it falls
        ei_i = 1'b1; rst65_i = 1'b1;
        @(negedge clk);
        ei_i = 1'b0; rst65_i = 1'b0;
        @(negedge clk);
        check("R5 level not held", 32'(status_o[5]), 32'h0);
        check("R5 no irq", 32'(irq_o), 32'h0);

        // R10: accepted ack wins over simultaneous enable
        intr_i = 1'b1;
        @(negedge clk);
        check("R7 general offered", 32'(irq_o), 32'h1);
        ack_i = 1'b1; ei_i = 1'b1;
        @(negedge clk);
        check("R10 ack over ei", 32'(status_o[3]), 32'h0);
        quiet_inputs();

        // R1: mid-run reset restores masks
        set_mask_i = 1'b1; mask_data_i = 8'h08;
        @(negedge clk);
        quiet_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 re-reset status", 32'(status_o), 32'h07);
        check("R1 re-reset irq", 32'(irq_o), 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule